// File: doc/BRIEF.md
# Debug Abstract Command Error Tracker

This block sits beside the abstract command engine of a debug module. It watches the register port the debugger uses, where every access carries a register-class tag. From those accesses it decides whether a new abstract command may start, and it tells the hart side to begin through a single-cycle launch pulse. It then follows the command until the hart reports completion and the code the command ended with.

While a command runs, some debugger accesses count as misuse. Any access to a data or program-buffer register is misuse. So is a write to the command, auto-execute or status register. A misuse is remembered as pending, and the in-flight command is never disturbed. On the completion edge a pending misuse wins: the 3-bit error field becomes 1 (busy), and the hart's own code is thrown away. Without misuse, the hart's code is stored if the field was clear.

The field is sticky. It is cleared by writing ones to its bits through the status register while no command runs. The FSM has three states:
- `S_IDLE`: no command is running.
- `S_RUN`: a command is running and no misuse has been seen.
- `S_RUN_VIOL`: a command is running and misuse is pending.

The transitions are:
- launch: `S_IDLE`→`S_RUN`.
- violate: `S_RUN`→`S_RUN_VIOL`.
- finish: `S_RUN`/`S_RUN_VIOL`→`S_IDLE` when the hart reports done.

Top module: `abscmd_err_tracker`

## Requirements
- R1: After synchronous reset, busy is 0, the error field is 0 and no launch pulse is driven.
- R2: A command-class write (class 2) while busy is 0 and the error field is 0 drives the launch pulse in that same cycle, and busy reads 1 after the next clock edge.
- R3: A command-class write while the error field is nonzero is ignored: no launch pulse, and busy stays 0.
- R4: A hart completion while busy clears busy on that edge. If no misuse occurred, the error field takes the hart's 3-bit code (for example 3 = exception).
- R5: A read or write of a data (class 3) or program-buffer (class 4) register while busy sets the error field to 1 on the next edge if it was 0.
- R6: A write to the status (class 0), auto-execute (class 1) or command (class 2) register while busy leaves the error field at 1 after completion, whatever code the hart reports.
- R7: A command-class write while busy launches nothing, and busy stays 1 until the hart completes.
- R8: A status-class write while busy is 0 clears the error bits at the positions where the write data holds 1 and keeps the others.
- R9: Reads of the status, auto-execute or command classes while busy are not misuse, and the hart's code is stored at completion.
- R10: Data or program-buffer accesses, and status, auto-execute or command reads, while busy is 0 change neither busy nor the error field.
- R11: A hart completion while busy is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Debugger register access this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_class | input | 3 | Register class: 0 status, 1 auto-execute, 2 command, 3 data, 4 program buffer |
| acc_wdata | input | 3 | Write-one-to-clear mask for the error field on status writes |
| hart_done | input | 1 | Hart reports that the running command has completed |
| hart_err | input | 3 | Error code the command finished with, valid with hart_done |
| cmd_launch | output | 1 | Single-cycle pulse telling the hart to start the command |
| busy | output | 1 | A command is in flight |
| cmderr | output | 3 | Sticky command error field |

## Verification
The main sweep covers every access class, both as a read and as a write, injected in the middle of a running command. Each run finishes with a nonzero hart code, so the bench can tell whether the final field shows the busy code or the hart's code. That separates the classes that count as misuse from those that do not. A second sweep completes clean commands with all eight hart codes, which shows the code is stored bit for bit. Further runs cover these cases:
- the same accesses while idle,
- partial write-one-to-clear masks,
- command writes blocked by a standing error,
- a completion arriving while no command runs,
- misuse in the same cycle as completion.

// File: rtl/acmd_pkg.sv
package acmd_pkg;
    localparam int ERR_W   = 3;
    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        CL_STATUS  = 3'd0,
        CL_AUTO    = 3'd1,
        CL_COMMAND = 3'd2,
        CL_DATA    = 3'd3,
        CL_PROGBUF = 3'd4
    } acc_class_e;

    localparam logic [ERR_W-1:0] ERR_NONE = '0;
    localparam logic [ERR_W-1:0] ERR_BUSY = ERR_W'(1);

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_RUN      = 2'd1,
        S_RUN_VIOL = 2'd2
    } run_state_e;
endpackage

// File: rtl/acmd_access_decode.sv
module acmd_access_decode
    import acmd_pkg::*;
#(
    parameter int CW = CLASS_W
) (
    input  logic          acc_valid,
    input  logic          acc_we,
    input  logic [CW-1:0] acc_class,
    input  logic          busy,
    input  logic          err_clear,
    output logic          cmd_write,
    output logic          stat_write,
    output logic          mem_viol,
    output logic          any_viol,
    output logic          launch
);
    logic is_mem, is_ctrl;

    always_comb begin
        is_mem     = (acc_class == CL_DATA) || (acc_class == CL_PROGBUF);
        is_ctrl    = (acc_class == CL_STATUS) || (acc_class == CL_AUTO) ||
                     (acc_class == CL_COMMAND);
        cmd_write  = acc_valid && acc_we && (acc_class == CL_COMMAND);
        stat_write = acc_valid && acc_we && (acc_class == CL_STATUS);
        mem_viol   = busy && acc_valid && is_mem;
        any_viol   = mem_viol || (busy && acc_valid && acc_we && is_ctrl);
        launch     = cmd_write && !busy && err_clear;
    end
endmodule

// File: rtl/acmd_run_fsm.sv
module acmd_run_fsm
    import acmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic any_viol,
    input  logic hart_done,
    output logic busy,
    output logic pending
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (launch) state_d = S_RUN;
            S_RUN:      if (hart_done) state_d = S_IDLE;
                        else if (any_viol) state_d = S_RUN_VIOL;
            S_RUN_VIOL: if (hart_done) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        pending = 1'b0;
        unique case (state_q)
            S_IDLE:     ;
            S_RUN:      busy = 1'b1;
            S_RUN_VIOL: begin busy = 1'b1; pending = 1'b1; end
            default:    ;
        endcase
    end
endmodule

// File: rtl/acmd_err_reg.sv
module acmd_err_reg
    import acmd_pkg::*;
#(
    parameter int EW = ERR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic          pending,
    input  logic          any_viol,
    input  logic          mem_viol,
    input  logic          hart_done,
    input  logic [EW-1:0] hart_err,
    input  logic          stat_write,
    input  logic [EW-1:0] clr_mask,
    output logic [EW-1:0] cmderr
);
    logic [EW-1:0] err_d;

    always_comb begin
        err_d = cmderr;
        if (busy && hart_done) begin
            if (pending || any_viol)   err_d = EW'(ERR_BUSY);
            else if (cmderr == '0)     err_d = hart_err;
        end else if (mem_viol && cmderr == '0) begin
            err_d = EW'(ERR_BUSY);
        end else if (!busy && stat_write) begin
            err_d = cmderr & ~clr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmderr <= '0;
        else     cmderr <= err_d;
    end
endmodule

// File: rtl/abscmd_err_tracker.sv
module abscmd_err_tracker
    import acmd_pkg::*;
#(
    parameter int EW = ERR_W,
    parameter int CW = CLASS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic          acc_we,
    input  logic [CW-1:0] acc_class,
    input  logic [EW-1:0] acc_wdata,
    input  logic          hart_done,
    input  logic [EW-1:0] hart_err,
    output logic          cmd_launch,
    output logic          busy,
    output logic [EW-1:0] cmderr
);
    logic cmd_write, stat_write, mem_viol, any_viol, pending;

    acmd_access_decode #(.CW(CW)) u_dec (
        .acc_valid (acc_valid),
        .acc_we    (acc_we),
        .acc_class (acc_class),
        .busy      (busy),
        .err_clear (cmderr == '0),
        .cmd_write (cmd_write),
        .stat_write(stat_write),
        .mem_viol  (mem_viol),
        .any_viol  (any_viol),
        .launch    (cmd_launch)
    );

    acmd_run_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .launch   (cmd_launch),
        .any_viol (any_viol),
        .hart_done(hart_done),
        .busy     (busy),
        .pending  (pending)
    );

    acmd_err_reg #(.EW(EW)) u_err (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .pending   (pending),
        .any_viol  (any_viol),
        .mem_viol  (mem_viol),
        .hart_done (hart_done),
        .hart_err  (hart_err),
        .stat_write(stat_write),
        .clr_mask  (acc_wdata),
        .cmderr    (cmderr)
    );
endmodule

// File: rtl/acmd_chk.sv
module acmd_chk #(
    parameter int EW = 3,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_valid,
    input logic          acc_we,
    input logic [CW-1:0] acc_class,
    input logic          hart_done,
    input logic [EW-1:0] hart_err,
    input logic          cmd_launch,
    input logic          busy,
    input logic [EW-1:0] cmderr
);
    logic mem_acc, ctrl_wr, viol_now, seen_q;

    always_comb begin
        mem_acc  = acc_valid && (acc_class == CW'(3) || acc_class == CW'(4));
        ctrl_wr  = acc_valid && acc_we && (acc_class <= CW'(2));
        viol_now = busy && (mem_acc || ctrl_wr);
    end

    always_ff @(posedge clk) begin
        if (rst || !busy || hart_done) seen_q <= 1'b0;
        else if (viol_now)             seen_q <= 1'b1;
    end

    // R2
    launch_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_launch |=> busy);

    // R3
    no_launch_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cmderr != '0) |-> !cmd_launch);

    // R7
    no_launch_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_launch);

    // R4
    done_drops_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && hart_done) |=> !busy);

    // R5
    mem_access_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_acc && !hart_done && cmderr == '0) |=> (cmderr == EW'(1)));

    // R6
    viol_final_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && hart_done && (seen_q || viol_now)) |=> (cmderr == EW'(1)));

    // R11
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && hart_done && !acc_valid) |=> (!busy && $stable(cmderr)));
endmodule

bind abscmd_err_tracker acmd_chk #(.EW(EW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_we    (acc_we),
    .acc_class (acc_class),
    .hart_done (hart_done),
    .hart_err  (hart_err),
    .cmd_launch(cmd_launch),
    .busy      (busy),
    .cmderr    (cmderr)
);

// File: tb/abscmd_err_tracker_test.sv
module abscmd_err_tracker_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid, acc_we, hart_done;
    logic [2:0] acc_class, acc_wdata, hart_err;
    logic       cmd_launch, busy;
    logic [2:0] cmderr;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done_flag = 1'b0;

    always #10 clk = ~clk;

    abscmd_err_tracker uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_class(acc_class), .acc_wdata(acc_wdata), .hart_done(hart_done),
        .hart_err(hart_err), .cmd_launch(cmd_launch), .busy(busy), .cmderr(cmderr)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic quiet();
        acc_valid = 0; acc_we = 0; acc_class = 0; acc_wdata = 0;
        hart_done = 0; hart_err = 0;
    endtask

    task automatic access(int cls, bit we, logic [2:0] mask);
        acc_valid = 1; acc_we = we; acc_class = 3'(cls); acc_wdata = mask;
        cyc();
        quiet();
    endtask

    task automatic start_cmd(string req, bit expect_go);
        acc_valid = 1; acc_we = 1; acc_class = 3'd2;
        #1;
        chk(req, int'(cmd_launch), int'(expect_go));
        cyc();
        quiet();
        chk(req, int'(busy), int'(expect_go));
    endtask

    task automatic finish(logic [2:0] code);
        hart_done = 1; hart_err = code;
        cyc();
        quiet();
    endtask

    task automatic clear_all();
        access(0, 1'b1, 3'b111);
    endtask

    initial begin
        quiet();
        rst = 1;
        cyc(); cyc();
        rst = 0;
        // R1
        chk("R1 busy", int'(busy), 0);
        chk("R1 cmderr", int'(cmderr), 0);
        chk("R1 launch", int'(cmd_launch), 0);

        // R2 R4: clean runs with every hart code
        for (int c = 0; c < 8; c++) begin
            start_cmd("R2", 1'b1);
            cyc();
            chk("R2 busy held", int'(busy), 1);
            finish(3'(c));
            chk("R4 busy", int'(busy), 0);
            chk("R4 code", int'(cmderr), c);
            clear_all();
            chk("R8 full clear", int'(cmderr), 0);
        end

        // R5 R6 R9: every class and direction mid-run, hart reports 3
        for (int cls = 0; cls < 5; cls++) begin
            for (int we = 0; we < 2; we++) begin
                automatic bit viol = (cls >= 3) || (we == 1);
                start_cmd("R2", 1'b1);
                acc_valid = 1; acc_we = 1'(we); acc_class = 3'(cls); acc_wdata = 3'b111;
                #1;
                chk("R7 no launch", int'(cmd_launch), 0);
                cyc();
                quiet();
                chk("R7 busy", int'(busy), 1);
                if (cls >= 3) chk("R5 intermediate", int'(cmderr), 1);
                finish(3'd3);
                chk("R4 busy", int'(busy), 0);
                chk(viol ? "R6 final" : "R9 final", int'(cmderr), viol ? 1 : 3);
                clear_all();
            end
        end

        // R6: misuse in the same cycle as completion
        start_cmd("R2", 1'b1);
        acc_valid = 1; acc_we = 1; acc_class = 3'd1;
        hart_done = 1; hart_err = 3'd3;
        cyc(); quiet();
        chk("R6 same-cycle", int'(cmderr), 1);
        clear_all();

        // R10: idle accesses without effect
        for (int cls = 0; cls < 5; cls++) begin
            for (int we = 0; we < 2; we++) begin
                if (!(cls == 2 && we == 1)) begin
                    access(cls, 1'(we), 3'b111);
                    chk("R10 busy", int'(busy), 0);
                    chk("R10 cmderr", int'(cmderr), 0);
                end
            end
        end

        // R11
        finish(3'd5);
        chk("R11 busy", int'(busy), 0);
        chk("R11 cmderr", int'(cmderr), 0);

        // R8 R3: partial clear, blocked launch
        start_cmd("R2", 1'b1);
        finish(3'd3);
        chk("R4 code", int'(cmderr), 3);
        start_cmd("R3", 1'b0);
        access(0, 1'b1, 3'b001);
        chk("R8 partial", int'(cmderr), 2);
        start_cmd("R3", 1'b0);
        access(0, 1'b1, 3'b100);
        chk("R8 zero bit", int'(cmderr), 2);
        access(0, 1'b1, 3'b010);
        chk("R8 cleared", int'(cmderr), 0);
        start_cmd("R2 after clear", 1'b1);
        finish(3'd0);

        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule